// File: doc/BRIEF.md
# Two-Packet Bulk IN Transmit Buffer

This block sits between endpoint firmware and the serial engine of a USB bulk IN endpoint. Firmware pushes bytes one at a time. A packet is closed either automatically, when its 64th byte is written, or early, when firmware pulses a short-packet strobe; a strobe with nothing loaded closes a zero-length packet. Up to two closed packets are held at once in two 64-byte buffers used alternately, so firmware can fill one while the serial side reads the other.

The serial side pops the bytes of the oldest closed packet in order, sees a marker on the final byte, and pulses a sent acknowledge once the packet has left; that frees the buffer and lowers the closed-packet count. A service request tells firmware there is room for one more packet. Bytes pushed while both buffers hold closed packets are dropped and raise a sticky overflow flag. A flush input empties everything, the partial packet included.

Top module: `bulkin_txfifo`

## Requirements
- R1: After reset the closed-packet count is 0, the service request is 1, read-valid is 0 and the overflow flag is 0.
- R2: The write of the 64th byte of a packet closes it; the count rises by one in the cycle after that write, and not after the 63rd.
- R3: A short-packet strobe closes the current packet with exactly the bytes loaded so far, including a byte written in the same cycle; with none loaded it closes a zero-length packet, which counts as a packet but never shows read-valid.
- R4: The service request is 1 while the count is 0 or 1 and 0 while the count is 2; the count never exceeds 2.
- R5: While two packets are closed, byte writes and short-packet strobes are ignored (stored data and count unchanged), and a write sets the overflow flag, which stays set until flush.
- R6: The serial side reads the oldest closed packet's bytes in write order, one per accepted pop; the last-byte marker is 1 only on the final byte, and read-valid falls after the final byte is popped.
- R7: A sent pulse with at least one closed packet frees the oldest packet, lowers the count by one and makes the next older packet the one read; a sent pulse in the same cycle as a packet close leaves the count unchanged.
- R8: Flush discards both buffers and the partial packet and clears the overflow flag; the count returns to 0 and the next packet holds only bytes written after the flush.
- R9: A sent pulse while the count is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all stored and partial data |
| wr_en | input | 1 | Firmware byte write strobe |
| wr_data | input | 8 | Firmware byte |
| short_pkt | input | 1 | Close the current packet early |
| ovf_err | output | 1 | Sticky: a write was dropped while full |
| svc_req | output | 1 | Room for another packet |
| pkt_cnt | output | 2 | Number of closed packets held |
| rd_en | input | 1 | Serial side pops one byte |
| rd_data | output | 8 | Current byte of the oldest packet |
| rd_valid | output | 1 | rd_data holds an unread byte |
| rd_last | output | 1 | rd_data is the packet's final byte |
| pkt_sent | input | 1 | Oldest packet has been transmitted |

## Verification
Every packet length from 0 to 64 is loaded, read back and acknowledged, so a design that closed a packet one byte early or late, mislabelled the final byte or let a zero-length packet show data would miss a byte comparison or a count check. Both buffers are filled to show the service request dropping and writes being refused; a design that stored the refused byte would append it to the following packet. A close and a sent acknowledge in the same cycle catch a count that takes only one of the two, and a flush with a partial packet open catches stale bytes leaking into the next packet.

// File: rtl/txf_pkg.sv
package txf_pkg;
    localparam int unsigned NUM_BUFS = 2;
    typedef logic [1:0] pcnt_t;
endpackage

// File: rtl/txf_fill.sv
module txf_fill #(
    parameter int unsigned PKT_BYTES = 64,
    parameter int unsigned DATA_W    = 8,
    localparam int unsigned LEN_W    = $clog2(PKT_BYTES + 1),
    localparam int unsigned ADDR_W   = $clog2(PKT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              short_pkt,
    input  logic              full,
    output logic              mem_we,
    output logic              mem_sel,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              close,
    output logic [LEN_W-1:0]  close_len,
    output logic              ovf
);
    typedef struct packed {
        logic [LEN_W-1:0] wcnt;
        logic             wsel;
        logic             ovf;
    } fill_st_t;

    fill_st_t st_d, st_q;
    logic             accept;
    logic [LEN_W-1:0] next_len;

    always_comb begin
        st_d      = st_q;
        mem_we    = 1'b0;
        close     = 1'b0;
        accept    = wr_en && !full;
        next_len  = st_q.wcnt + LEN_W'(accept);
        close_len = next_len;
        if (flush) begin
            st_d = '0;
        end else begin
            if (wr_en && full) st_d.ovf = 1'b1;
            mem_we = accept;
            if (!full && ((accept && st_q.wcnt == LEN_W'(PKT_BYTES - 1)) || short_pkt)) begin
                close     = 1'b1;
                st_d.wcnt = '0;
                st_d.wsel = ~st_q.wsel;
            end else begin
                st_d.wcnt = next_len;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_sel  = st_q.wsel;
    assign mem_addr = st_q.wcnt[ADDR_W-1:0];
    assign mem_data = wr_data;
    assign ovf      = st_q.ovf;

    assert_full_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !flush) |=> (ovf && $stable(st_q.wcnt)));

    assert_auto_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full && !flush && st_q.wcnt == LEN_W'(PKT_BYTES - 1)) |=> (st_q.wcnt == '0));

    assert_flush_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.wcnt == '0 && !ovf));
endmodule

// File: rtl/txf_store.sv
module txf_store #(
    parameter int unsigned PKT_BYTES = 64,
    parameter int unsigned DATA_W    = 8,
    localparam int unsigned LEN_W    = $clog2(PKT_BYTES + 1),
    localparam int unsigned ADDR_W   = $clog2(PKT_BYTES),
    localparam int unsigned DEPTH    = txf_pkg::NUM_BUFS * PKT_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              wsel,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              close,
    input  logic [LEN_W-1:0]  close_len,
    input  logic              rsel,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic [LEN_W-1:0]  head_len
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [LEN_W-1:0]  len_q [txf_pkg::NUM_BUFS];

    always_ff @(posedge clk) begin
        if (we) mem_q[{wsel, waddr}] <= wdata;
    end

    for (genvar b = 0; b < int'(txf_pkg::NUM_BUFS); b++) begin : g_len
        logic [LEN_W-1:0] len_d;
        always_comb begin
            len_d = len_q[b];
            if (close && wsel == 1'(b)) len_d = close_len;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) len_q[b] <= '0;
            else        len_q[b] <= len_d;
        end
    end

    assign rdata    = mem_q[{rsel, raddr}];
    assign head_len = len_q[rsel];

    assert_len_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        close |-> (close_len <= LEN_W'(PKT_BYTES)));
endmodule

// File: rtl/txf_drain.sv
module txf_drain #(
    parameter int unsigned PKT_BYTES = 64,
    localparam int unsigned LEN_W    = $clog2(PKT_BYTES + 1),
    localparam int unsigned ADDR_W   = $clog2(PKT_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic                close,
    input  logic                rd_en,
    input  logic                pkt_sent,
    input  logic [LEN_W-1:0]    head_len,
    output logic                rsel,
    output logic [ADDR_W-1:0]   raddr,
    output logic                rd_valid,
    output logic                rd_last,
    output logic                full,
    output txf_pkg::pcnt_t      cnt
);
    typedef struct packed {
        txf_pkg::pcnt_t   cnt;
        logic             rsel;
        logic [LEN_W-1:0] rptr;
    } drain_st_t;

    drain_st_t st_d, st_q;
    logic      pop;

    always_comb begin
        rd_valid = (st_q.cnt != '0) && (st_q.rptr < head_len);
        rd_last  = rd_valid && (st_q.rptr == head_len - 1'b1);
        pop      = pkt_sent && (st_q.cnt != '0);
        st_d     = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (pop) begin
                st_d.rsel = ~st_q.rsel;
                st_d.rptr = '0;
            end else if (rd_en && rd_valid) begin
                st_d.rptr = st_q.rptr + 1'b1;
            end
            case ({close, pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsel  = st_q.rsel;
    assign raddr = st_q.rptr[ADDR_W-1:0];
    assign full  = (st_q.cnt == 2'd2);
    assign cnt   = st_q.cnt;

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= 2'd2);

    assert_last_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_last && !pkt_sent && !flush) |=> !rd_valid);

    assert_sent_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_sent && st_q.cnt != '0 && !close && !flush) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));

    assert_idle_sent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_sent && st_q.cnt == '0 && !close && !flush) |=> (st_q.cnt == '0));

    assert_flush_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.cnt == '0 && !rd_valid));
endmodule

// File: rtl/bulkin_txfifo.sv
module bulkin_txfifo #(
    parameter int unsigned PKT_BYTES = 64,
    parameter int unsigned DATA_W    = 8,
    localparam int unsigned LEN_W    = $clog2(PKT_BYTES + 1),
    localparam int unsigned ADDR_W   = $clog2(PKT_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              short_pkt,
    output logic              ovf_err,
    output logic              svc_req,
    output logic [1:0]        pkt_cnt,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_last,
    input  logic              pkt_sent
);
    logic              full;
    logic              mem_we, mem_sel, close, rsel;
    logic [ADDR_W-1:0] mem_addr, raddr;
    logic [DATA_W-1:0] mem_data;
    logic [LEN_W-1:0]  close_len, head_len;

    txf_fill #(.PKT_BYTES(PKT_BYTES), .DATA_W(DATA_W)) i_fill (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
        .short_pkt(short_pkt), .full(full), .mem_we(mem_we), .mem_sel(mem_sel),
        .mem_addr(mem_addr), .mem_data(mem_data), .close(close),
        .close_len(close_len), .ovf(ovf_err)
    );

    txf_store #(.PKT_BYTES(PKT_BYTES), .DATA_W(DATA_W)) i_store (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .wsel(mem_sel), .waddr(mem_addr),
        .wdata(mem_data), .close(close), .close_len(close_len), .rsel(rsel),
        .raddr(raddr), .rdata(rd_data), .head_len(head_len)
    );

    txf_drain #(.PKT_BYTES(PKT_BYTES)) i_drain (
        .clk(clk), .rst_n(rst_n), .flush(flush), .close(close), .rd_en(rd_en),
        .pkt_sent(pkt_sent), .head_len(head_len), .rsel(rsel), .raddr(raddr),
        .rd_valid(rd_valid), .rd_last(rd_last), .full(full), .cnt(pkt_cnt)
    );

    assign svc_req = !full;

    assert_full_blocks_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !close);

    assert_pingpong_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_cnt == 2'd1 && !flush) |-> (mem_sel != rsel));
endmodule

// File: tb/test_bulkin_txfifo.sv
module test_bulkin_txfifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0, wr_en = 1'b0, short_pkt = 1'b0, rd_en = 1'b0, pkt_sent = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ovf_err, svc_req, rd_valid, rd_last;
    logic [1:0] pkt_cnt;
    logic [7:0] rd_data;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    bulkin_txfifo i_bulkin_txfifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
        .short_pkt(short_pkt), .ovf_err(ovf_err), .svc_req(svc_req), .pkt_cnt(pkt_cnt),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .rd_last(rd_last),
        .pkt_sent(pkt_sent)
    );

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37 + i * 5 + 1) & 255);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe();
        short_pkt = 1'b1;
        @(negedge clk);
        short_pkt = 1'b0;
    endtask

    task automatic sent();
        pkt_sent = 1'b1;
        @(negedge clk);
        pkt_sent = 1'b0;
    endtask

    task automatic load(input int len, input int seed);
        for (int i = 0; i < len; i++) wr_byte(pat(seed, i));
        if (len < 64) strobe();
    endtask

    task automatic drain(input int len, input int seed, input string req);
        for (int i = 0; i < len; i++) begin
            chk({req, " valid"}, int'(rd_valid), 1);
            chk({req, " data"}, int'(rd_data), int'(pat(seed, i)));
            chk({req, " last"}, int'(rd_last), int'(i == len - 1));
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        chk({req, " valid after end"}, int'(rd_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cnt", int'(pkt_cnt), 0);
        chk("R1 svc", int'(svc_req), 1);
        chk("R1 valid", int'(rd_valid), 0);
        chk("R1 ovf", int'(ovf_err), 0);

        // R2/R3/R6 sweep over every length
        for (int len = 0; len <= 64; len++) begin
            for (int i = 0; i < len; i++) begin
                if (i == 63) chk("R2 not closed early", int'(pkt_cnt), 0);
                wr_byte(pat(len, i));
            end
            if (len < 64) begin
                chk("R3 open before strobe", int'(pkt_cnt), 0);
                strobe();
            end
            chk(len == 64 ? "R2 auto close" : "R3 short close", int'(pkt_cnt), 1);
            chk("R4 svc with one", int'(svc_req), 1);
            drain(len, len, len == 0 ? "R3 zero length" : "R6 read");
            sent();
            chk("R7 freed", int'(pkt_cnt), 0);
        end

        // R3 byte and strobe in the same cycle
        for (int i = 0; i < 3; i++) wr_byte(pat(90, i));
        wr_en = 1'b1; wr_data = pat(90, 3); short_pkt = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; short_pkt = 1'b0;
        chk("R3 same-cycle close", int'(pkt_cnt), 1);
        drain(4, 90, "R3 same-cycle data");
        sent();

        // R9 sent with nothing held
        sent();
        chk("R9 cnt stays 0", int'(pkt_cnt), 0);
        load(2, 91);
        chk("R9 next packet cnt", int'(pkt_cnt), 1);
        drain(2, 91, "R9 next packet");
        sent();

        // R4/R5 two packets held
        load(10, 100);
        load(64, 101);
        chk("R4 cnt two", int'(pkt_cnt), 2);
        chk("R4 svc low", int'(svc_req), 0);
        wr_byte(8'hEE);
        chk("R5 ovf set", int'(ovf_err), 1);
        chk("R5 cnt kept", int'(pkt_cnt), 2);
        strobe();
        chk("R5 strobe ignored", int'(pkt_cnt), 2);
        drain(10, 100, "R5 first packet intact");
        sent();
        chk("R7 cnt one", int'(pkt_cnt), 1);
        chk("R4 svc back", int'(svc_req), 1);
        for (int i = 0; i < 3; i++) wr_byte(pat(102, i));
        drain(64, 101, "R7 older packet next");
        // R7 close and sent in one cycle
        pkt_sent = 1'b1; short_pkt = 1'b1;
        @(negedge clk);
        pkt_sent = 1'b0; short_pkt = 1'b0;
        chk("R7 simultaneous cnt", int'(pkt_cnt), 1);
        drain(3, 102, "R5 dropped byte absent");
        chk("R5 ovf sticky", int'(ovf_err), 1);
        sent();

        // R8 flush with a closed and a partial packet
        load(7, 110);
        for (int i = 0; i < 5; i++) wr_byte(8'h55);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk("R8 cnt", int'(pkt_cnt), 0);
        chk("R8 valid", int'(rd_valid), 0);
        chk("R8 ovf cleared", int'(ovf_err), 0);
        chk("R8 svc", int'(svc_req), 1);
        load(2, 111);
        chk("R8 new cnt", int'(pkt_cnt), 1);
        drain(2, 111, "R8 no stale bytes");
        sent();
        chk("R8 final cnt", int'(pkt_cnt), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule